// File: doc/BRIEF.md
# I2C Slave Receiver/Transmitter with 10-bit Addressing

This block is a slave-only I2C engine clocked by the system clock. It oversamples the SCL and SDA pads through a synchroniser and finds SCL edges and START/STOP conditions there. After each START it compares the first byte against a host-programmed address register. In 7-bit mode that byte is either a match or not. In 10-bit mode a match on the high pattern opens a second address phase. The host then reloads the address register with the low eight address bits, and the next byte must match them.

Bytes that are accepted move from the shift register into a single holding buffer, which raises the interrupt flag and sets the buffer-full flag. Reception is double-buffered: the next byte shifts in while the host reads the last one. In a read transfer the slave sends the buffer contents MSB first, and it stops sending when the master withholds its acknowledge. The pads are modelled as open-drain drive enables only. The slave never stretches SCL and never answers the general call address.

Top module: `i2c10_slave`

## Requirements
- R1: After reset, sda_oe and scl_oe are 0, and buf_full, ovf, irq, st_start and st_stop all read 0.
- R2: A START (SDA falling while SCL is high) sets st_start and clears st_stop. A STOP (SDA rising while SCL is high) sets st_stop and clears st_start.
- R3: In 7-bit mode, the first byte after START is a match when its bits 7..1 equal addr register bits 7..1. On a match the slave pulls SDA low for the ninth SCL period (ACK). On a mismatch it leaves SDA released and ignores the bus until the next START.
- R4: A matched address byte is placed in the buffer with st_data=0. Its bit 0 is reported on st_read (1 = master reads).
- R5: In 10-bit mode, the first byte is a match when its bits 7..1 equal addr register bits 7..1 and its bit 0 is 0. The host loads the pattern 11110,A9,A8,0 for this compare. A match is ACKed and sets st_addr_upd. The following byte must equal all eight bits of the reloaded addr register. A match is ACKed; either outcome clears st_addr_upd, and a mismatch is not ACKed.
- R6: In a write transfer, each data byte is ACKed and stored in the buffer with st_data=1, buf_full=1 and irq=1. A buf_rd pulse clears buf_full, and an irq_clr pulse clears irq.
- R7: A byte that completes while buf_full is 1 sets ovf, leaves the buffer unchanged and is not ACKed.
- R8: In a read transfer, the slave shifts out the buffer MSB first and changes SDA only after SCL falls. It reloads from the buffer after each master ACK. After a master NACK it keeps SDA released until the next START.
- R9: cfg_mode selects the operating mode: 4'b0110 7-bit, 4'b0111 10-bit, 4'b1110 7-bit with start/stop interrupt, 4'b1111 10-bit with start/stop interrupt, and 4'b1011 idle. Only 4'b1110 and 4'b1111 set irq on START or STOP. In idle mode, with any other code, or with cfg_en=0, the slave never drives SDA and records no START/STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Block enable |
| cfg_mode | input | 4 | Mode select |
| addr_wr | input | 1 | Address register write strobe |
| addr_wdata | input | 8 | Address register write data |
| buf_wr | input | 1 | Buffer write strobe (transmit data) |
| buf_wdata | input | 8 | Buffer write data |
| buf_rd | input | 1 | Buffer read strobe, clears buf_full |
| irq_clr | input | 1 | Clears irq |
| ovf_clr | input | 1 | Clears ovf |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe | output | 1 | SCL pull-low enable (never asserted) |
| sda_oe | output | 1 | SDA pull-low enable |
| buf_q | output | 8 | Data buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | Receive overflow flag |
| irq | output | 1 | Interrupt flag |
| st_start | output | 1 | Last bus condition was START |
| st_stop | output | 1 | Last bus condition was STOP |
| st_data | output | 1 | Last buffered byte was data (1) or address (0) |
| st_read | output | 1 | Current transfer is a read |
| st_addr_upd | output | 1 | Next byte completes a 10-bit address |

## Verification
The bench aims at the second phase of the 10-bit match. A design that compares the low byte against the stale high pattern, or that never clears the update flag, would ACK the wrong address or leave st_addr_upd stuck. It sends a byte while the buffer is still full. A design that overwrote the buffer, or ACKed that byte, would lose the unread byte without a trace. It also runs a read transfer ended by a master NACK, where a slave that kept driving would corrupt the following clocks. Finally, it brings up start/stop interrupts in a mode where they are disabled, and drives the bus with the block turned off, to catch a decoder that lets these events through.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [3:0] MODE_S7     = 4'b0110;
  localparam logic [3:0] MODE_S10    = 4'b0111;
  localparam logic [3:0] MODE_S7_SS  = 4'b1110;
  localparam logic [3:0] MODE_S10_SS = 4'b1111;
  localparam logic [3:0] MODE_IDLE   = 4'b1011;

  // role of the byte currently being shifted
  typedef enum logic [2:0] {PH_OFF, PH_AD1, PH_AD2, PH_RX, PH_TX} phase_t;
  // position inside one nine-clock byte frame
  typedef enum logic [1:0] {ST_DATA, ST_ACKW, ST_ACKD, ST_ACKE} stage_t;

  typedef struct packed {
    logic run;
    logic ten;
    logic ss_irq;
  } mode_t;

  function automatic mode_t decode_mode(input logic en, input logic [3:0] m);
    mode_t d;
    d = '0;
    case (m)
      MODE_S7:     d.run = en;
      MODE_S10:    begin d.run = en; d.ten = 1'b1; end
      MODE_S7_SS:  begin d.run = en; d.ss_irq = 1'b1; end
      MODE_S10_SS: begin d.run = en; d.ten = 1'b1; d.ss_irq = 1'b1; end
      default:     d = '0; // idle code and unused codes
    endcase
    return d;
  endfunction
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pad,
  input  logic sda_pad,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  // [STAGES-1] is the synchronised level, [STAGES] the previous one
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_lvl, scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_pad};
      sda_sh <= {sda_sh[STAGES-1:0], sda_pad};
    end
  end

  assign scl_lvl  = scl_sh[STAGES-1];
  assign scl_prev = scl_sh[STAGES];
  assign sda_lvl  = sda_sh[STAGES-1];
  assign sda_prev = sda_sh[STAGES];

  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c10_engine.sv
module i2c10_engine
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ten,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_lvl,
  input  logic [BYTE_W-1:0] addr_q,
  input  logic [BYTE_W-1:0] buf_q,
  input  logic              buf_full,
  output logic              sda_oe,
  output logic              push,
  output logic [BYTE_W-1:0] push_byte,
  output logic              push_data,
  output logic              tx_ack_ev,
  output logic              rw,
  output logic              upd
);
  phase_t              phase_q, phase_d;
  stage_t              stage_q, stage_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-1:0]   rxsr_q, rxsr_d, txsr_q, txsr_d;
  logic                oe_q, oe_d, ackgo_q, ackgo_d;
  logic                rw_q, rw_d, upd_q, upd_d, hiok_q, hiok_d;
  logic [BYTE_W-1:0]   rx_byte;
  logic                hi_match, ack;

  assign rx_byte  = {rxsr_q[BYTE_W-2:0], sda_lvl};
  assign hi_match = (rx_byte[BYTE_W-1:1] == addr_q[BYTE_W-1:1]);

  always_comb begin
    phase_d   = phase_q;
    stage_d   = stage_q;
    cnt_d     = cnt_q;
    rxsr_d    = rxsr_q;
    txsr_d    = txsr_q;
    oe_d      = oe_q;
    ackgo_d   = ackgo_q;
    rw_d      = rw_q;
    upd_d     = upd_q;
    hiok_d    = hiok_q;
    push      = 1'b0;
    push_byte = rx_byte;
    push_data = 1'b0;
    tx_ack_ev = 1'b0;
    ack       = 1'b0;
    if (!run) begin
      phase_d = PH_OFF;
      stage_d = ST_DATA;
      cnt_d   = '0;
      oe_d    = 1'b0;
      ackgo_d = 1'b0;
      rw_d    = 1'b0;
      upd_d   = 1'b0;
      hiok_d  = 1'b0;
    end else if (start_ev) begin
      phase_d = PH_AD1;
      stage_d = ST_DATA;
      cnt_d   = '0;
      oe_d    = 1'b0;
      ackgo_d = 1'b0;
      upd_d   = 1'b0;
    end else if (stop_ev) begin
      phase_d = PH_OFF;
      stage_d = ST_DATA;
      cnt_d   = '0;
      oe_d    = 1'b0;
      ackgo_d = 1'b0;
      upd_d   = 1'b0;
      hiok_d  = 1'b0;
    end else if (scl_rise) begin
      case (stage_q)
        ST_DATA: begin
          rxsr_d = rx_byte;
          if (cnt_q == CNT_W'(BYTE_W - 1)) begin
            cnt_d   = '0;
            stage_d = ST_ACKW;
            case (phase_q)
              PH_AD1: begin
                if (!ten) begin
                  if (hi_match) begin
                    push    = 1'b1;
                    ack     = ~buf_full;
                    rw_d    = rx_byte[0];
                    phase_d = ack ? (rx_byte[0] ? PH_TX : PH_RX) : PH_OFF;
                  end else begin
                    phase_d = PH_OFF;
                  end
                end else if (hi_match && !rx_byte[0]) begin
                  push    = 1'b1;
                  ack     = ~buf_full;
                  rw_d    = 1'b0;
                  upd_d   = ack;
                  phase_d = ack ? PH_AD2 : PH_OFF;
                end else if (hi_match && hiok_q) begin
                  // repeated START turning a matched 10-bit write into a read
                  push    = 1'b1;
                  ack     = ~buf_full;
                  rw_d    = 1'b1;
                  phase_d = ack ? PH_TX : PH_OFF;
                end else begin
                  phase_d = PH_OFF;
                end
              end
              PH_AD2: begin
                upd_d = 1'b0;
                if (rx_byte == addr_q) begin
                  push    = 1'b1;
                  ack     = ~buf_full;
                  hiok_d  = ack;
                  phase_d = ack ? PH_RX : PH_OFF;
                end else begin
                  phase_d = PH_OFF;
                end
              end
              PH_RX: begin
                push      = 1'b1;
                push_data = 1'b1;
                ack       = ~buf_full;
              end
              default: ack = 1'b0;
            endcase
            ackgo_d = ack;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_ACKD: begin
          stage_d = ST_ACKE;
          if (phase_q == PH_TX) begin
            if (sda_lvl) phase_d = PH_OFF;
            else         tx_ack_ev = 1'b1;
          end
        end
        default: stage_d = stage_q;
      endcase
    end else if (scl_fall) begin
      case (stage_q)
        ST_ACKW: begin
          stage_d = ST_ACKD;
          oe_d    = ackgo_q;
        end
        ST_ACKE: begin
          stage_d = ST_DATA;
          ackgo_d = 1'b0;
          if (phase_q == PH_TX) begin
            txsr_d = buf_q;
            oe_d   = ~buf_q[BYTE_W-1];
          end else begin
            oe_d = 1'b0;
          end
        end
        ST_DATA: begin
          if (phase_q == PH_TX) begin
            txsr_d = {txsr_q[BYTE_W-2:0], 1'b0};
            oe_d   = ~txsr_q[BYTE_W-2];
          end
        end
        default: stage_d = stage_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      stage_q <= ST_DATA;
      cnt_q   <= '0;
      rxsr_q  <= '0;
      txsr_q  <= '0;
      oe_q    <= 1'b0;
      ackgo_q <= 1'b0;
      rw_q    <= 1'b0;
      upd_q   <= 1'b0;
      hiok_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      stage_q <= stage_d;
      cnt_q   <= cnt_d;
      rxsr_q  <= rxsr_d;
      txsr_q  <= txsr_d;
      oe_q    <= oe_d;
      ackgo_q <= ackgo_d;
      rw_q    <= rw_d;
      upd_q   <= upd_d;
      hiok_q  <= hiok_d;
    end
  end

  assign sda_oe = oe_q;
  assign rw     = rw_q;
  assign upd    = upd_q;

  // R3: outside a read, SDA is pulled only in the acknowledge slot
  assert_ack_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && phase_q != PH_TX) |-> (stage_q == ST_ACKD || stage_q == ST_ACKE));

  // R9: an inactive mode releases the bus on the next cycle
  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !oe_q);

  // R5: the update flag only stands while the second address byte is due
  assert_upd_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (phase_q == PH_AD2));

  // R8: once the master NACKs, the slave is released on the following fall
  assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OFF && stage_q == ST_DATA) |-> !oe_q);
endmodule

// File: rtl/i2c10_hostregs.sv
module i2c10_hostregs
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_irq,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_byte,
  input  logic              push_data,
  input  logic              tx_ack_ev,
  input  logic              buf_rd,
  input  logic              buf_wr,
  input  logic [BYTE_W-1:0] buf_wdata,
  input  logic              addr_wr,
  input  logic [BYTE_W-1:0] addr_wdata,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] buf_q,
  output logic [BYTE_W-1:0] addr_q,
  output logic              full_q,
  output logic              ovf_q,
  output logic              irq_q,
  output logic              st_start_q,
  output logic              st_stop_q,
  output logic              st_dna_q
);
  logic [BYTE_W-1:0] buf_d, addr_d;
  logic full_d, ovf_d, irq_d, st_start_d, st_stop_d, st_dna_d;
  logic full_eff, accept;

  assign full_eff = full_q & ~buf_rd;
  assign accept   = push & ~full_eff;

  always_comb begin
    buf_d      = buf_q;
    addr_d     = addr_wr ? addr_wdata : addr_q;
    full_d     = full_q & ~buf_rd;
    ovf_d      = ovf_q & ~ovf_clr;
    st_dna_d   = st_dna_q;
    st_start_d = st_start_q;
    st_stop_d  = st_stop_q;
    if (push) begin
      if (full_eff) begin
        ovf_d = 1'b1;
      end else begin
        buf_d    = push_byte;
        full_d   = 1'b1;
        st_dna_d = push_data;
      end
    end else if (buf_wr) begin
      buf_d = buf_wdata;
    end
    if (ev_start) begin
      st_start_d = 1'b1;
      st_stop_d  = 1'b0;
    end else if (ev_stop) begin
      st_start_d = 1'b0;
      st_stop_d  = 1'b1;
    end
    irq_d = (irq_q & ~irq_clr) | accept | tx_ack_ev | (ss_irq & (ev_start | ev_stop));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q      <= '0;
      addr_q     <= '0;
      full_q     <= 1'b0;
      ovf_q      <= 1'b0;
      irq_q      <= 1'b0;
      st_start_q <= 1'b0;
      st_stop_q  <= 1'b0;
      st_dna_q   <= 1'b0;
    end else begin
      buf_q      <= buf_d;
      addr_q     <= addr_d;
      full_q     <= full_d;
      ovf_q      <= ovf_d;
      irq_q      <= irq_d;
      st_start_q <= st_start_d;
      st_stop_q  <= st_stop_d;
      st_dna_q   <= st_dna_d;
    end
  end

  // R7: a byte arriving on a full buffer is dropped and flagged
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full_q && !buf_rd) |=> (ovf_q && buf_q == $past(buf_q)));

  // R2: a START leaves start set and stop clear
  assert_start_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (st_start_q && !st_stop_q));

  // R6: an accepted byte marks the buffer full and raises the interrupt
  assert_push_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full_q) |=> (full_q && irq_q));
endmodule

// File: rtl/i2c10_slave.sv
module i2c10_slave
  import i2c10_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en,
  input  logic [3:0] cfg_mode,
  input  logic       addr_wr,
  input  logic [7:0] addr_wdata,
  input  logic       buf_wr,
  input  logic [7:0] buf_wdata,
  input  logic       buf_rd,
  input  logic       irq_clr,
  input  logic       ovf_clr,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] buf_q,
  output logic       buf_full,
  output logic       ovf,
  output logic       irq,
  output logic       st_start,
  output logic       st_stop,
  output logic       st_data,
  output logic       st_read,
  output logic       st_addr_upd
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  mode_t             mode;
  logic              sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic              push, push_data, tx_ack_ev;
  logic [BYTE_W-1:0] push_byte, addr_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign mode   = decode_mode(cfg_en, cfg_mode);
  assign scl_oe = 1'b0;

  i2c10_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .scl_pad  (scl_i),
    .sda_pad  (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c10_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (mode.run),
    .ten       (mode.ten),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_lvl   (sda_lvl),
    .addr_q    (addr_q),
    .buf_q     (buf_q),
    .buf_full  (buf_full),
    .sda_oe    (sda_oe),
    .push      (push),
    .push_byte (push_byte),
    .push_data (push_data),
    .tx_ack_ev (tx_ack_ev),
    .rw        (st_read),
    .upd       (st_addr_upd)
  );

  i2c10_hostregs u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ss_irq     (mode.ss_irq),
    .ev_start   (start_ev & mode.run),
    .ev_stop    (stop_ev & mode.run),
    .push       (push),
    .push_byte  (push_byte),
    .push_data  (push_data),
    .tx_ack_ev  (tx_ack_ev),
    .buf_rd     (buf_rd),
    .buf_wr     (buf_wr),
    .buf_wdata  (buf_wdata),
    .addr_wr    (addr_wr),
    .addr_wdata (addr_wdata),
    .irq_clr    (irq_clr),
    .ovf_clr    (ovf_clr),
    .buf_q      (buf_q),
    .addr_q     (addr_q),
    .full_q     (buf_full),
    .ovf_q      (ovf),
    .irq_q      (irq),
    .st_start_q (st_start),
    .st_stop_q  (st_stop),
    .st_dna_q   (st_data)
  );
endmodule

// File: tb/i2c10_slave_test.sv
module i2c10_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 16;
  localparam int Q  = HP / 2;
  localparam int WATCHDOG = 150000;
  localparam int NVEC = 7;
  // {mode, address register, address byte, expected ACK}
  localparam logic [20:0] VECS [NVEC] = '{
    {4'b0110, 8'hA4, 8'hA4, 1'b1},
    {4'b0110, 8'hA4, 8'hA6, 1'b0},
    {4'b0110, 8'h3C, 8'h3C, 1'b1},
    {4'b1110, 8'h3C, 8'h3C, 1'b1},
    {4'b1011, 8'hA4, 8'hA4, 1'b0},
    {4'b0111, 8'hF4, 8'hF4, 1'b1},
    {4'b0111, 8'hF4, 8'hF6, 1'b0}
  };

  logic clk, rst_n, cfg_en, addr_wr, buf_wr, buf_rd, irq_clr, ovf_clr;
  logic [3:0] cfg_mode;
  logic [7:0] addr_wdata, buf_wdata, buf_q;
  logic scl_oe, sda_oe, buf_full, ovf, irq, st_start, st_stop, st_data, st_read, st_addr_upd;
  logic m_scl_low, m_sda_low, scl_bus, sda_bus;
  int total, bad, cycles;

  assign scl_bus = ~(m_scl_low | scl_oe);
  assign sda_bus = ~(m_sda_low | sda_oe);

  i2c10_slave uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .buf_rd(buf_rd), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .buf_q(buf_q), .buf_full(buf_full), .ovf(ovf), .irq(irq),
    .st_start(st_start), .st_stop(st_stop), .st_data(st_data),
    .st_read(st_read), .st_addr_upd(st_addr_upd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_clear();
    buf_rd = 1'b1; irq_clr = 1'b1; ovf_clr = 1'b1;
    tick(1);
    buf_rd = 1'b0; irq_clr = 1'b0; ovf_clr = 1'b0;
    tick(1);
  endtask

  task automatic host_addr(input logic [7:0] a);
    addr_wr = 1'b1; addr_wdata = a;
    tick(1);
    addr_wr = 1'b0;
    tick(1);
  endtask

  task automatic host_read();
    buf_rd = 1'b1;
    tick(1);
    buf_rd = 1'b0;
    tick(1);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; m_scl_low = 1'b0;
    tick(HP);
    m_sda_low = 1'b1;
    tick(HP);
    m_scl_low = 1'b1;
    tick(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1;
    tick(Q);
    m_scl_low = 1'b0;
    tick(HP);
    m_sda_low = 1'b0;
    tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i];
      tick(Q);
      m_scl_low = 1'b0;
      tick(HP);
      m_scl_low = 1'b1;
      tick(Q);
    end
  endtask

  // ninth clock of a write byte; optional host reload while SCL is high
  task automatic ack_clock(output logic got, input logic do_host, input logic [7:0] wv);
    m_sda_low = 1'b0;
    tick(Q);
    m_scl_low = 1'b0;
    tick(Q);
    got = ~sda_bus;
    if (do_host) begin
      buf_rd = 1'b1; tick(1); buf_rd = 1'b0;
      buf_wr = 1'b1; buf_wdata = wv; tick(1); buf_wr = 1'b0;
      tick(Q - 2);
    end else begin
      tick(Q);
    end
    m_scl_low = 1'b1;
    tick(Q);
  endtask

  task automatic read_byte(output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl_low = 1'b0;
      tick(Q);
      b[i] = sda_bus;
      tick(Q);
      m_scl_low = 1'b1;
      tick(Q);
    end
  endtask

  task automatic master_ack(input logic give, input logic do_host, input logic [7:0] wv);
    m_sda_low = give;
    tick(Q);
    m_scl_low = 1'b0;
    if (do_host) begin
      buf_rd = 1'b1; tick(1); buf_rd = 1'b0;
      buf_wr = 1'b1; buf_wdata = wv; tick(1); buf_wr = 1'b0;
      tick(HP - 2);
    end else begin
      tick(HP);
    end
    m_scl_low = 1'b1;
    tick(Q);
    m_sda_low = 1'b0;
  endtask

  initial begin
    logic [20:0] v;
    logic got;
    logic [7:0] rb;
    total = 0; bad = 0; cycles = 0;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_mode = 4'b0000;
    addr_wr = 1'b0; addr_wdata = '0; buf_wr = 1'b0; buf_wdata = '0;
    buf_rd = 1'b0; irq_clr = 1'b0; ovf_clr = 1'b0;
    m_scl_low = 1'b0; m_sda_low = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 irq", irq, 0);
    chk("R1 st_start", st_start, 0);
    chk("R1 st_stop", st_stop, 0);

    // R2 and R9: conditions and their interrupt gating
    cfg_en = 1'b1; cfg_mode = 4'b0110;
    tick(2);
    bus_start();
    chk("R2 start flag", st_start, 1);
    chk("R2 stop clear", st_stop, 0);
    chk("R9 no start irq in plain mode", irq, 0);
    bus_stop();
    chk("R2 stop flag", st_stop, 1);
    chk("R2 start clear", st_start, 0);
    cfg_mode = 4'b1110;
    host_clear();
    bus_start();
    chk("R9 start irq in interrupt mode", irq, 1);
    bus_stop();

    // vector table: address compare across modes
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      cfg_mode = v[20:17];
      host_clear();
      host_addr(v[16:9]);
      bus_start();
      send_byte(v[8:1]);
      ack_clock(got, 1'b0, 8'h00);
      chk("R3/R5/R9 address ack", got, v[0]);
      if (v[0]) begin
        chk("R4 address in buffer", buf_q, v[8:1]);
        chk("R4 address marked", st_data, 0);
      end
      bus_stop();
    end

    // R5, R6, R7: two-phase 10-bit write, then overflow
    cfg_mode = 4'b0111;
    host_clear();
    host_addr(8'hF4);
    bus_start();
    send_byte(8'hF4);
    ack_clock(got, 1'b0, 8'h00);
    chk("R5 high byte ack", got, 1);
    chk("R5 update flag set", st_addr_upd, 1);
    host_read();
    host_addr(8'h5A);
    send_byte(8'h5A);
    ack_clock(got, 1'b0, 8'h00);
    chk("R5 low byte ack", got, 1);
    chk("R5 update flag clear", st_addr_upd, 0);
    chk("R5 low byte buffered", buf_q, 8'h5A);
    host_clear();
    send_byte(8'h33);
    ack_clock(got, 1'b0, 8'h00);
    chk("R6 data ack", got, 1);
    chk("R6 data byte", buf_q, 8'h33);
    chk("R6 data flag", st_data, 1);
    chk("R6 full", buf_full, 1);
    chk("R6 irq", irq, 1);
    send_byte(8'h44);
    ack_clock(got, 1'b0, 8'h00);
    chk("R7 nack on full", got, 0);
    chk("R7 ovf set", ovf, 1);
    chk("R7 buffer kept", buf_q, 8'h33);
    bus_stop();
    host_clear();
    chk("R6 irq cleared", irq, 0);
    chk("R6 full cleared", buf_full, 0);

    // R5: low byte mismatch
    host_addr(8'hF4);
    bus_start();
    send_byte(8'hF4);
    ack_clock(got, 1'b0, 8'h00);
    host_read();
    host_addr(8'h5A);
    send_byte(8'h5B);
    ack_clock(got, 1'b0, 8'h00);
    chk("R5 low mismatch nack", got, 0);
    chk("R5 update flag dropped", st_addr_upd, 0);
    bus_stop();

    // R8: read transfer ended by master NACK
    cfg_mode = 4'b0110;
    host_clear();
    host_addr(8'hA4);
    bus_start();
    send_byte(8'hA5);
    ack_clock(got, 1'b1, 8'hC3);
    chk("R3 read address ack", got, 1);
    chk("R4 read flag", st_read, 1);
    read_byte(rb);
    chk("R8 first byte", rb, 8'hC3);
    master_ack(1'b1, 1'b1, 8'h5A);
    read_byte(rb);
    chk("R8 second byte", rb, 8'h5A);
    master_ack(1'b0, 1'b0, 8'h00);
    tick(4);
    chk("R8 released after nack", sda_oe, 0);
    read_byte(rb);
    chk("R8 silent after nack", rb, 8'hFF);
    bus_stop();

    // R9: disabled block ignores the bus
    cfg_en = 1'b0;
    host_clear();
    bus_start();
    chk("R9 disabled no start", st_start, 0);
    send_byte(8'hA4);
    ack_clock(got, 1'b0, 8'h00);
    chk("R9 disabled no ack", got, 0);
    bus_stop();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule